// File: doc/BRIEF.md
# TFT Panel Row and Frame Strobe Generator

This block derives the row and frame control strobes for a small portrait TFT panel from one pixel clock. It produces five signals: a single-clock line latch, a single-clock start pulse, a frame start strobe two lines wide, an active-low polarity/clear strobe, and a line-reversal signal that alternates every line. The line length is not set directly. It is computed from the pixel clock rate, the frame rate and the total line count (visible lines plus blanking lines) by integer division. With the defaults (6 MHz, 60 Hz, 320 + 9 lines) this gives 303 clocks per line.

When `enable` rises, the generators do not all start at once. The reversal generator runs first. The line latch generator joins once the reversal count has passed a threshold. The start pulse, frame start and polarity/clear generators then start together once the line latch count reaches a second threshold. Each generator's counter starts from zero at that moment. `seq_done_o` reports that the full sequence has run. Dropping `enable` stops every generator at the same clock edge and returns all outputs to their idle levels. Raising `enable` again replays the sequence from the start.

Top module: `tftc_timing_top`

## Requirements
- R1: After reset and while disabled, `line_latch_o`, `start_pulse_o`, `frame_start_o`, `line_rev_o` and `seq_done_o` are 0 and `pol_clr_n_o` is 1.
- R2: Once running, `line_rev_o` is 1 for the first LINE_CLKS clocks of each window of 2*LINE_CLKS clocks, counted from the reversal generator's start. LINE_CLKS = PIX_HZ / FRAME_HZ / (VIS_LINES + BLANK_LINES), using integer division.
- R3: Once running, `line_latch_o` is 1 for exactly one clock at the start of every LINE_CLKS-clock period.
- R4: Once running, `start_pulse_o` is 1 for exactly one clock at the start of every LINE_CLKS-clock period.
- R5: Once running, `frame_start_o` is 1 for the first 2*LINE_CLKS clocks of every period of (VIS_LINES + BLANK_LINES)*LINE_CLKS clocks.
- R6: Once running, `pol_clr_n_o` is 0 for the first H_PIXELS + CLS_EXTRA clocks of each LINE_CLKS period and 1 for the rest of that period.
- R7: The reversal generator starts at the first clock edge that samples `enable` high. The line latch generator starts at the first later edge at which the reversal count is greater than REV_ARM. With the defaults this is 13 clocks after the reversal start.
- R8: The start pulse, frame start and polarity/clear generators start together at the first edge at which the line latch count is at least LP_ARM. With the defaults this is 4 clocks after the line latch start.
- R9: `seq_done_o` rises in the cycle in which the last three generators start, and it stays high until the block is disabled.
- R10: An edge that samples `enable` low stops all generators. From the next cycle all outputs are at their R1 levels. A later enable restarts the sequence as in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run request, level sensitive |
| line_latch_o | output | 1 | One-clock line latch pulse |
| start_pulse_o | output | 1 | One-clock start pulse per line |
| frame_start_o | output | 1 | Frame start strobe, two lines wide |
| pol_clr_n_o | output | 1 | Polarity/clear strobe, active low |
| line_rev_o | output | 1 | Alternating line-reversal level |
| seq_done_o | output | 1 | Start-up sequence complete |

## Verification
The bench builds the block with PIX_HZ=160, FRAME_HZ=1, VIS_LINES=6, BLANK_LINES=2, H_PIXELS=10 and CLS_EXTRA=2. This gives 20-clock lines and a 160-clock frame, with the two start thresholds left at their defaults. At these sizes several full frames fit into a short run, including the frame strobe's wrap and its two-line width. Disables can be placed before the line latch starts, between the two start stages, and in the middle of a frame, and each is followed by a restart.

// File: rtl/tftc_pkg.sv
package tftc_pkg;

  // Clocks in one line: pixel rate over frame rate over total lines (integer)
  function automatic int unsigned line_clks(input int unsigned pix_hz,
                                            input int unsigned frame_hz,
                                            input int unsigned total_lines);
    return (pix_hz / frame_hz) / total_lines;
  endfunction

  // Counter width that can hold values up to max_val
  function automatic int unsigned cnt_bits(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction

endpackage

// File: rtl/tftc_pulse_gen.sv
module tftc_pulse_gen #(
  parameter int unsigned PERIOD = 4,
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned CW     = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          stop,
  output logic          active,
  output logic [CW-1:0] cnt,
  output logic          pulse
);
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);
  localparam logic [CW-1:0] WID  = CW'(WIDTH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (stop) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (start) begin
      active <= 1'b1;
      cnt    <= '0;
    end else if (active) begin
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end

  assign pulse = active && (cnt < WID);
endmodule

// File: rtl/tftc_sequencer.sv
module tftc_sequencer #(
  parameter int unsigned CW      = 8,
  parameter int unsigned REV_ARM = 11,
  parameter int unsigned LP_ARM  = 3
) (
  input  logic          enable,
  input  logic          rev_act,
  input  logic [CW-1:0] rev_cnt,
  input  logic          lp_act,
  input  logic [CW-1:0] lp_cnt,
  input  logic          grp_act,
  output logic          stop_all,
  output logic          rev_start,
  output logic          lp_start,
  output logic          grp_start
);
  localparam logic [CW-1:0] REV_T = CW'(REV_ARM);
  localparam logic [CW-1:0] LP_T  = CW'(LP_ARM);

  always_comb begin
    stop_all  = !enable;
    rev_start = enable && !rev_act;
    lp_start  = enable && rev_act && (rev_cnt > REV_T) && !lp_act;
    grp_start = enable && lp_act && (lp_cnt >= LP_T) && !grp_act;
  end
endmodule

// File: rtl/tftc_timing_top.sv
module tftc_timing_top #(
  parameter int unsigned PIX_HZ      = 6_000_000,
  parameter int unsigned FRAME_HZ    = 60,
  parameter int unsigned VIS_LINES   = 320,
  parameter int unsigned BLANK_LINES = 9,
  parameter int unsigned H_PIXELS    = 240,
  parameter int unsigned CLS_EXTRA   = 8,
  parameter int unsigned REV_ARM     = 11,
  parameter int unsigned LP_ARM      = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  output logic line_latch_o,
  output logic start_pulse_o,
  output logic frame_start_o,
  output logic pol_clr_n_o,
  output logic line_rev_o,
  output logic seq_done_o
);
  import tftc_pkg::*;

  localparam int unsigned TOTAL_LINES = VIS_LINES + BLANK_LINES;
  localparam int unsigned LINE_CLKS   = line_clks(PIX_HZ, FRAME_HZ, TOTAL_LINES);
  localparam int unsigned FRAME_CLKS  = LINE_CLKS * TOTAL_LINES;
  localparam int unsigned CW          = cnt_bits(FRAME_CLKS);
  localparam int unsigned NGRP        = 3;
  // group members: 0 start pulse, 1 frame start, 2 polarity/clear
  localparam int unsigned GRP_PERIOD [NGRP] = '{LINE_CLKS, FRAME_CLKS, LINE_CLKS};
  localparam int unsigned GRP_WIDTH  [NGRP] = '{1, 2 * LINE_CLKS, H_PIXELS + CLS_EXTRA};

  // named internal events, used by the checker
  logic          stop_all, rev_start, lp_start, grp_start;
  logic          rev_act, lp_act;
  logic [CW-1:0] rev_cnt, lp_cnt;
  logic          rev_pulse, lp_pulse;
  logic [NGRP-1:0] grp_act_v, grp_pulse_v;
  logic          grp_act;

  assign grp_act = grp_act_v[0];

  tftc_sequencer #(.CW(CW), .REV_ARM(REV_ARM), .LP_ARM(LP_ARM)) u_seq (
    .enable   (enable),
    .rev_act  (rev_act),
    .rev_cnt  (rev_cnt),
    .lp_act   (lp_act),
    .lp_cnt   (lp_cnt),
    .grp_act  (grp_act),
    .stop_all (stop_all),
    .rev_start(rev_start),
    .lp_start (lp_start),
    .grp_start(grp_start)
  );

  tftc_pulse_gen #(.PERIOD(2 * LINE_CLKS), .WIDTH(LINE_CLKS), .CW(CW)) u_rev (
    .clk(clk), .rst_n(rst_n), .start(rev_start), .stop(stop_all),
    .active(rev_act), .cnt(rev_cnt), .pulse(rev_pulse)
  );

  tftc_pulse_gen #(.PERIOD(LINE_CLKS), .WIDTH(1), .CW(CW)) u_lp (
    .clk(clk), .rst_n(rst_n), .start(lp_start), .stop(stop_all),
    .active(lp_act), .cnt(lp_cnt), .pulse(lp_pulse)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic [CW-1:0] cnt_unused;
    tftc_pulse_gen #(.PERIOD(GRP_PERIOD[g]), .WIDTH(GRP_WIDTH[g]), .CW(CW)) u_gen (
      .clk(clk), .rst_n(rst_n), .start(grp_start), .stop(stop_all),
      .active(grp_act_v[g]), .cnt(cnt_unused), .pulse(grp_pulse_v[g])
    );
  end

  assign line_rev_o    = rev_pulse;
  assign line_latch_o  = lp_pulse;
  assign start_pulse_o = grp_pulse_v[0];
  assign frame_start_o = grp_pulse_v[1];
  assign pol_clr_n_o   = !grp_pulse_v[2];
  assign seq_done_o    = grp_act;
endmodule

// File: rtl/tftc_checker.sv
module tftc_checker (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic rev_act,
  input logic lp_act,
  input logic line_latch_o,
  input logic start_pulse_o,
  input logic frame_start_o,
  input logic pol_clr_n_o,
  input logic line_rev_o,
  input logic seq_done_o
);
  a_r10_disable_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!line_latch_o && !start_pulse_o && !frame_start_o &&
                 pol_clr_n_o && !line_rev_o && !seq_done_o));

  a_r7_lp_after_rev: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lp_act) |-> (rev_act && $past(rev_act)));

  a_r8_grp_after_lp: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seq_done_o) |-> (lp_act && $past(lp_act)));

  a_r3_latch_single: assert property (@(posedge clk) disable iff (!rst_n)
    line_latch_o |=> !line_latch_o);

  a_r4_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse_o |=> !start_pulse_o);

  a_r6_clear_covers_start: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse_o |-> !pol_clr_n_o);

  a_r9_done_implies_running: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done_o |-> (lp_act && rev_act));
endmodule

bind tftc_timing_top tftc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable),
  .rev_act(rev_act), .lp_act(lp_act),
  .line_latch_o(line_latch_o), .start_pulse_o(start_pulse_o),
  .frame_start_o(frame_start_o), .pol_clr_n_o(pol_clr_n_o),
  .line_rev_o(line_rev_o), .seq_done_o(seq_done_o)
);

// File: tb/tftc_timing_top_test.sv
module tftc_timing_top_test;
  localparam int PIX = 160, FHZ = 1, VIS = 6, BLK = 2, HP = 10, CE = 2;
  localparam int LINE  = (PIX / FHZ) / (VIS + BLK);   // 20
  localparam int FRAME = LINE * (VIS + BLK);          // 160
  localparam int CLSW  = HP + CE;                     // 12

  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0;
  logic lp, sp, fs, cls_n, rev, done;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  tftc_timing_top #(.PIX_HZ(PIX), .FRAME_HZ(FHZ), .VIS_LINES(VIS), .BLANK_LINES(BLK),
                    .H_PIXELS(HP), .CLS_EXTRA(CE)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .line_latch_o(lp), .start_pulse_o(sp), .frame_start_o(fs),
    .pol_clr_n_o(cls_n), .line_rev_o(rev), .seq_done_o(done));

  // behavioural reference: elapsed time per stage since its launch, -1 when idle
  int t_rev = -1, t_lp = -1, t_grp = -1;
  int since_en = -1;

  always @(posedge clk) begin
    if (!rst_n || !enable) begin
      t_rev = -1; t_lp = -1; t_grp = -1; since_en = -1;
    end else begin
      bit go_lp, go_grp;
      go_lp  = (t_rev >= 0) && ((t_rev % (2 * LINE)) > 11) && (t_lp < 0);
      go_grp = (t_lp >= 0) && ((t_lp % LINE) >= 3) && (t_grp < 0);
      if (t_rev >= 0) t_rev++;
      if (t_lp  >= 0) t_lp++;
      if (t_grp >= 0) t_grp++;
      if (t_rev < 0) t_rev = 0;
      if (go_lp)  t_lp = 0;
      if (go_grp) t_grp = 0;
      since_en++;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R2", "line_rev", int'(rev), (t_rev >= 0 && (t_rev % (2*LINE)) < LINE) ? 1 : 0);
    chk("R3", "line_latch", int'(lp), (t_lp >= 0 && (t_lp % LINE) == 0) ? 1 : 0);
    chk("R4", "start_pulse", int'(sp), (t_grp >= 0 && (t_grp % LINE) == 0) ? 1 : 0);
    chk("R5", "frame_start", int'(fs), (t_grp >= 0 && (t_grp % FRAME) < 2*LINE) ? 1 : 0);
    chk("R6", "pol_clr_n", int'(cls_n), (t_grp >= 0 && (t_grp % LINE) < CLSW) ? 0 : 1);
    chk("R9", "seq_done", int'(done), (t_grp >= 0) ? 1 : 0);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare_all();
    end
  endtask

  task automatic idle_check(input string req);
    chk(req, "idle outputs {lp,sp,fs,rev,done,cls_n}",
        {lp, sp, fs, rev, done, cls_n}, 6'b000001);
  endtask

  task automatic main_seq();
    int first_lp, first_sp, fs_high;
    repeat (3) @(negedge clk);
    idle_check("R1");
    rst_n = 1'b1;
    run(5);
    idle_check("R1");

    // R7/R8: launch timing from the enable
    enable = 1'b1;
    first_lp = -1; first_sp = -1;
    for (int i = 1; i <= 40; i++) begin
      @(negedge clk);
      compare_all();
      if (lp && first_lp < 0) first_lp = i;
      if (sp && first_sp < 0) first_sp = i;
    end
    chk("R7", "cycles to first line latch", first_lp, 14);
    chk("R8", "cycles to first start pulse", first_sp, 18);

    // R5: frame strobe high count over one frame
    fs_high = 0;
    for (int i = 0; i < FRAME; i++) begin
      @(negedge clk);
      compare_all();
      if (fs) fs_high++;
    end
    chk("R5", "frame strobe clocks per frame", fs_high, 2*LINE);
    run(3 * FRAME + 7);

    // R10: disable mid-frame
    enable = 1'b0;
    @(negedge clk);
    idle_check("R10");
    run(10);

    // disable before the line latch starts
    enable = 1'b1; run(8);
    enable = 1'b0; @(negedge clk); idle_check("R10");
    run(3);
    // disable between the two start stages
    enable = 1'b1; run(15);
    enable = 1'b0; @(negedge clk); idle_check("R10");
    run(3);
    // restart and long run (R7 replay)
    enable = 1'b1;
    run(2 * FRAME + 33);
    enable = 1'b0;
    run(5);
  endtask

  initial begin
    fork
      main_seq();
      begin
        repeat (20000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule